// File: doc/BRIEF.md
# Modulo Circular Buffer Address Corrector

This block sits behind an address generator and keeps pointer updates inside a circular buffer. Each cycle in which `in_valid` is high, it takes the pointer's current value, the signed step the generator wants to apply, and the inclusive low and high limits of the buffer. It forms the candidate address and, if the step carried it out of the buffer, folds it back by one buffer length. The result appears one clock later, together with a flag that says whether the pointer register should take the corrected value.

The direction of travel is the sign of the step. The boundary tests are inequalities, so a step that lands well past a limit is still brought back. Two update styles are supported. In the pre/post-modify style, the corrected address is also the new pointer value. In the base-plus-offset style, only the access address is corrected and the pointer keeps its old value. When bit-reversed addressing is active, a disable input turns correction off for write accesses. Read accesses are always corrected.

Top module: `modulo_addr_corrector`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `out_valid` is high. In any other cycle it is low. While `in_valid` is low, `out_ea` and `out_wb_en` keep their values.
- R2: For a positive step, a candidate `base + step` greater than `buf_hi` is reduced by the length `buf_hi - buf_lo + 1`.
- R3: A positive or negative step whose magnitude is at most the buffer length, and that jumps several words past a limit, still returns an address inside `[buf_lo, buf_hi]`.
- R4: For a negative step, a candidate below `buf_lo` is increased by the buffer length.
- R5: A candidate inside `[buf_lo, buf_hi]` is passed unchanged. This includes a candidate landing exactly on `buf_hi` or exactly on `buf_lo`.
- R6: A zero step returns `base` unchanged, even when `base` lies outside the buffer.
- R7: With `mode_offset` = 0 (pre/post-modify), `out_wb_en` is 1. With `mode_offset` = 1 (base plus offset), `out_wb_en` is 0 and `out_ea` is still corrected.
- R8: When `brev_active` = 1 and `is_write` = 1, no correction is applied and `out_ea` equals `base + step` modulo 2^AW. With `brev_active` = 1 and `is_write` = 0, correction still applies.
- R9: After reset, `out_valid`, `out_ea` and `out_wb_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: inputs carry a request this cycle |
| base | input | AW | Current pointer value |
| step | input | AW | Signed step (two's complement) |
| buf_lo | input | AW | Lowest address of the buffer (inclusive) |
| buf_hi | input | AW | Highest address of the buffer (inclusive) |
| mode_offset | input | 1 | 0 = pre/post-modify, 1 = base plus offset |
| is_write | input | 1 | 1 when the access is a data write |
| brev_active | input | 1 | Bit-reversed addressing is active |
| out_valid | output | 1 | Result valid |
| out_ea | output | AW | Corrected effective address |
| out_wb_en | output | 1 | Pointer register should take `out_ea` |

## Verification
The bench builds the block with the default AW = 16. This leaves room to place a buffer well clear of both ends of the address space, so every overshoot and undershoot, including steps of a full buffer length, is folded without the 16-bit sum wrapping. Directed cases cover landing exactly on each limit, jumping past each limit, and the zero step outside the buffer. A random sweep draws buffers of 1 to 256 words and steps up to the full length in either direction, and checks each result against an integer model in the bench.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;

  typedef enum logic {
    MODE_PREPOST = 1'b0,
    MODE_OFFSET  = 1'b1
  } upd_mode_e;

endpackage

// File: rtl/modaddr_fold.sv
module modaddr_fold #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic          bypass_i,
  output logic [AW-1:0] ea_o,
  output logic          hit_hi_o,
  output logic          hit_lo_o
);
  localparam int XW = AW + 2;

  function automatic logic signed [XW-1:0] widen_u(input logic [AW-1:0] v);
    return $signed({2'b00, v});
  endfunction

  function automatic logic signed [XW-1:0] widen_s(input logic [AW-1:0] v);
    return $signed({{2{v[AW-1]}}, v});
  endfunction

  logic signed [XW-1:0] cand_x;
  logic signed [XW-1:0] len_x;
  logic signed [XW-1:0] fixed_x;
  logic                 step_up;
  logic                 step_dn;

  always_comb begin
    cand_x   = widen_u(base_i) + widen_s(step_i);
    len_x    = widen_u(hi_i) - widen_u(lo_i) + XW'(1);
    step_dn  = step_i[AW-1];
    step_up  = !step_i[AW-1] && (|step_i);
    hit_hi_o = !bypass_i && step_up && (cand_x > widen_u(hi_i));
    hit_lo_o = !bypass_i && step_dn && (cand_x < widen_u(lo_i));
    if (hit_hi_o)      fixed_x = cand_x - len_x;
    else if (hit_lo_o) fixed_x = cand_x + len_x;
    else               fixed_x = cand_x;
    ea_o = fixed_x[AW-1:0];
  end

endmodule

// File: rtl/modaddr_out_reg.sv
module modaddr_out_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] ea_d,
  input  logic          wb_d,
  output logic          vld_o,
  output logic [AW-1:0] ea_o,
  output logic          wb_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      ea_o  <= '0;
      wb_o  <= 1'b0;
    end else begin
      vld_o <= load_i;
      if (load_i) begin
        ea_o <= ea_d;
        wb_o <= wb_d;
      end
    end
  end
endmodule

// File: rtl/modulo_addr_corrector.sv
module modulo_addr_corrector
  import modaddr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] buf_lo,
  input  logic [AW-1:0] buf_hi,
  input  logic          mode_offset,
  input  logic          is_write,
  input  logic          brev_active,
  output logic          out_valid,
  output logic [AW-1:0] out_ea,
  output logic          out_wb_en
);
  localparam int XW = AW + 2;

  upd_mode_e     upd_mode;
  logic          fold_bypass;
  logic          hit_hi;
  logic          hit_lo;
  logic [AW-1:0] ea_next;
  logic          wb_next;

  assign upd_mode    = upd_mode_e'(mode_offset);
  assign fold_bypass = brev_active && is_write;
  assign wb_next     = (upd_mode == MODE_PREPOST);

  modaddr_fold #(.AW(AW)) u_fold (
    .base_i   (base),
    .step_i   (step),
    .lo_i     (buf_lo),
    .hi_i     (buf_hi),
    .bypass_i (fold_bypass),
    .ea_o     (ea_next),
    .hit_hi_o (hit_hi),
    .hit_lo_o (hit_lo)
  );

  modaddr_out_reg #(.AW(AW)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (in_valid),
    .ea_d   (ea_next),
    .wb_d   (wb_next),
    .vld_o  (out_valid),
    .ea_o   (out_ea),
    .wb_o   (out_wb_en)
  );

  // Observation wires for the checks below
  logic signed [XW-1:0] chk_step_mag;
  logic signed [XW-1:0] chk_len;
  logic                 chk_base_in_buf;
  logic                 chk_step_fits;

  always_comb begin
    chk_len         = $signed({2'b00, buf_hi}) - $signed({2'b00, buf_lo}) + XW'(1);
    chk_step_mag    = step[AW-1] ? -$signed({{2{step[AW-1]}}, step})
                                 :  $signed({{2{step[AW-1]}}, step});
    chk_base_in_buf = (base >= buf_lo) && (base <= buf_hi) && (buf_lo <= buf_hi);
    chk_step_fits   = chk_step_mag <= chk_len;
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_ea) && $stable(out_wb_en)));
  a_r3_stays_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fold_bypass && chk_base_in_buf && chk_step_fits)
      |=> (out_ea >= $past(buf_lo) && out_ea <= $past(buf_hi)));
  a_r6_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && step == '0) |=> (out_ea == $past(base)));
  a_r7_offset_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_offset) |=> !out_wb_en);
  a_r7_prepost_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_offset) |=> out_wb_en);
  a_r8_write_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    fold_bypass |-> (!hit_hi && !hit_lo));
  a_r2_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    hit_hi |-> !step[AW-1]);

endmodule

// File: tb/test_modulo_addr_corrector.sv
module test_modulo_addr_corrector;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] step = '0;
  logic [AW-1:0] buf_lo = '0;
  logic [AW-1:0] buf_hi = '0;
  logic          mode_offset = 1'b0;
  logic          is_write = 1'b0;
  logic          brev_active = 1'b0;
  logic          out_valid;
  logic [AW-1:0] out_ea;
  logic          out_wb_en;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  modulo_addr_corrector #(.AW(AW)) i_modulo_addr_corrector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base(base), .step(step),
    .buf_lo(buf_lo), .buf_hi(buf_hi), .mode_offset(mode_offset),
    .is_write(is_write), .brev_active(brev_active),
    .out_valid(out_valid), .out_ea(out_ea), .out_wb_en(out_wb_en)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent integer model of the folding rule
  function automatic int model(input int b, input int s, input int lo, input int hi, input bit dis);
    int c;
    int len;
    c = b + s;
    len = hi - lo + 1;
    if (!dis && s > 0 && c > hi) c = c - len;
    else if (!dis && s < 0 && c < lo) c = c + len;
    return c & ((1 << AW) - 1);
  endfunction

  // Drive one request at a falling edge, sample after the next rising edge
  task automatic issue(input int b, input int s, input int lo, input int hi,
                       input bit offs, input bit wr, input bit br);
    @(negedge clk);
    in_valid = 1'b1; base = AW'(b); step = AW'(s);
    buf_lo = AW'(lo); buf_hi = AW'(hi);
    mode_offset = offs; is_write = wr; brev_active = br;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R9 valid", int'(out_valid), 0);
    check("R9 ea", int'(out_ea), 0);
    check("R9 wb", int'(out_wb_en), 0);
  endtask

  task automatic t_inside;
    issue('h1000, 2, 'h1000, 'h103F, 0, 0, 0);
    check("R5 inside", int'(out_ea), 'h1002);
    check("R1 valid", int'(out_valid), 1);
    issue('h103C, 3, 'h1000, 'h103F, 0, 0, 0);
    check("R5 land on hi", int'(out_ea), 'h103F);
    issue('h1002, -2, 'h1000, 'h103F, 0, 0, 0);
    check("R5 land on lo", int'(out_ea), 'h1000);
  endtask

  task automatic t_inc_wrap;
    issue('h103E, 2, 'h1000, 'h103F, 0, 0, 0);
    check("R2 wrap", int'(out_ea), 'h1000);
    issue('h1030, 'h30, 'h1000, 'h103F, 0, 0, 0);
    check("R3 overshoot up", int'(out_ea), 'h1020);
    issue('h1000, 'h40, 'h1000, 'h103F, 0, 0, 0);
    check("R3 full length up", int'(out_ea), 'h1000);
  endtask

  task automatic t_dec_wrap;
    issue('h1000, -2, 'h1000, 'h103F, 0, 0, 0);
    check("R4 wrap", int'(out_ea), 'h103E);
    issue('h1010, -'h30, 'h1000, 'h103F, 0, 0, 0);
    check("R3 overshoot down", int'(out_ea), 'h1020);
  endtask

  task automatic t_zero;
    issue('h2000, 0, 'h1000, 'h103F, 0, 0, 0);
    check("R6 zero step", int'(out_ea), 'h2000);
  endtask

  task automatic t_modes;
    issue('h103E, 2, 'h1000, 'h103F, 1, 0, 0);
    check("R7 offset ea", int'(out_ea), 'h1000);
    check("R7 offset wb", int'(out_wb_en), 0);
    issue('h103E, 2, 'h1000, 'h103F, 0, 0, 0);
    check("R7 prepost wb", int'(out_wb_en), 1);
  endtask

  task automatic t_brev;
    issue('h103E, 2, 'h1000, 'h103F, 0, 1, 1);
    check("R8 write bypass", int'(out_ea), 'h1040);
    issue('h103E, 2, 'h1000, 'h103F, 0, 0, 1);
    check("R8 read corrects", int'(out_ea), 'h1000);
    issue('h103E, 2, 'h1000, 'h103F, 0, 1, 0);
    check("R8 write no brev", int'(out_ea), 'h1000);
  endtask

  task automatic t_hold;
    issue('h1005, 1, 'h1000, 'h103F, 1, 0, 0);
    @(negedge clk);
    base = 'h3333; step = 'h11; mode_offset = 1'b0;
    @(posedge clk); #1;
    check("R1 no valid", int'(out_valid), 0);
    check("R1 hold ea", int'(out_ea), 'h1006);
    check("R1 hold wb", int'(out_wb_en), 0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++) begin
      int lo, len, hi, b, s;
      lo  = 'h2000 + int'($urandom_range(0, 'h4000));
      len = int'($urandom_range(1, 256));
      hi  = lo + len - 1;
      b   = lo + int'($urandom_range(0, len - 1));
      s   = int'($urandom_range(0, 2 * len)) - len;
      issue(b, s, lo, hi, 0, 0, 0);
      check("R3 random", int'(out_ea), model(b, s, lo, hi, 1'b0));
    end
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_inside();
    t_inc_wrap();
    t_dec_wrap();
    t_zero();
    t_modes();
    t_brev();
    t_hold();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule